// File: doc/BRIEF.md
# Bidirectional Waveform RAM Address Sequencer

This block produces read addresses for a waveform memory. The addresses sweep up from a programmed low bound to a programmed high bound, then back down, and turn around at each bound for as long as the sweep runs. Two configuration slots each hold a low bound, a high bound, a step period and an output destination bit. A select input picks the slot that is used.

A sweep starts on a one-cycle update pulse, or when the select input changes. A select change stops the running sweep and starts a new one with the parameters of the newly chosen slot. The slot's parameters are captured when the sweep starts. An internal timer sets the spacing between steps. In counted mode the step period is a number of core clocks. In data-clock mode the sweep takes one step on each cycle in which an external data-clock enable is high.

Each new address comes with a one-cycle read strobe. The block also outputs a direction flag, the index of the active slot and that slot's destination bit, so that the next stage can route the data.

Top module: `ram_sweep_seq`

## Requirements
- R1: After reset, and before any start event, `rd_addr_o` is 0, `rd_stb_o` is 0 and `slot_o` is 0.
- R2: An update pulse on `upd_i` in cycle T starts a sweep from the slot chosen by the synchronised select. In cycle T+1 the block presents that slot's low bound with `rd_stb_o`=1 and `dir_up_o`=1.
- R3: During a sweep the address moves by exactly one per step and always stays within the active slot's low and high bounds, inclusive.
- R4: On reaching the high bound the sweep turns downward, and on reaching the low bound it turns upward. `dir_up_o` reads 1 while counting up and 0 while counting down, and it takes its new value in the same cycle that the bound address is presented.
- R5: The select input `sel_i` passes through a two-flop synchroniser. A change driven during cycle D aborts the running sweep, and the low bound of the new slot is presented in cycle D+3. `slot_o` then shows the new slot index.
- R6: When the slot's destination bit is 0, consecutive read strobes are exactly M core clocks apart, where M is the slot's 16-bit rate field.
- R7: When the slot's destination bit is 1, the sweep steps once in each cycle in which `data_ce_i` is high. `dest_o` shows the active slot's destination bit.
- R8: An M value of 0 or 1 gives one step per clock.
- R9: If the low bound equals the high bound, the address stays at that value, `dir_up_o` stays 1, and the strobe keeps pulsing at the timer rate.
- R10: A start with the low bound greater than the high bound leaves the block idle, with address 0 and no strobes, until the next valid start.
- R11: `rd_stb_o` is high for exactly one clock for each newly presented address, including the first address of a sweep.
- R12: Slot k occupies bits [k*AW +: AW] of `lo_i` and `hi_i`, bits [k*16 +: 16] of `rate_i`, and bit k of `dest_i`. Here AW is 10 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_i | input | 1 | Start pulse: restarts the sweep from the selected slot |
| sel_i | input | 1 | Slot select; any change restarts the sweep |
| data_ce_i | input | 1 | Output-data clock enable, used for pacing in data-clock mode |
| lo_i | input | 20 | Low bound of each slot, packed |
| hi_i | input | 20 | High bound of each slot, packed |
| rate_i | input | 32 | Counted step period M of each slot, packed |
| dest_i | input | 2 | Destination / pacing-mode bit of each slot |
| rd_addr_o | output | 10 | RAM read address |
| rd_stb_o | output | 1 | One-cycle strobe for each new address |
| dir_up_o | output | 1 | 1 while counting up, 0 while counting down |
| slot_o | output | 1 | Index of the active slot |
| dest_o | output | 1 | Destination bit of the active slot |

## Verification
The bench targets these corner cases:
- **Turn-around points.** A design that steps once past a bound, or repeats a bound, would put a wrong address or direction in the scoreboard.
- **Direction flag timing.** A design that changes the flag one cycle late would report the wrong direction alongside the bound address.
- **Select restarts mid-sweep.** A design with the wrong synchroniser latency, or one that keeps the old slot, would show up in the cycle and value of the first address.
- **Degenerate timer values and bound cases.** With M of 0 or 1, a miscounting timer would change the spacing between strobes. With equal bounds, a walker that does not hold would wander off the bound. With inverted bounds, a walker that starts anyway would emit strobes that should not appear.

// File: rtl/rss_pkg.sv
// Package: shared widths and the per-slot configuration record used by the
// bidirectional address sequencer. Assumes exactly one module set per chip
// build uses these widths.
package rss_pkg;
    parameter int unsigned RSS_ADDR_W = 10;
    parameter int unsigned RSS_RATE_W = 16;

    typedef struct packed {
        logic [RSS_ADDR_W-1:0] lo;
        logic [RSS_ADDR_W-1:0] hi;
        logic [RSS_RATE_W-1:0] rate;
        logic                  dest;
    } slot_cfg_t;
endpackage

// File: rtl/rss_sel_sync.sv
// Two-flop synchroniser for the slot select plus change detection.
// Assumes sel_i may be asynchronous to clk; chg_o pulses for one cycle per
// settled change of the synchronised value.
module rss_sel_sync #(
    parameter int unsigned SEL_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    output logic [SEL_W-1:0] sel_o,
    output logic             chg_o
);
    logic [SEL_W-1:0] meta_q, sync_q, prev_q;

    // Shift the select through the synchroniser and keep the last settled value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= sel_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign sel_o = sync_q;
    assign chg_o = (sync_q != prev_q);
endmodule

// File: rtl/rss_step_timer.sv
// Step-rate timer. In counted mode it fires every max(rate,1) clocks; in
// data-clock mode it fires on each high data_ce_i. Assumes clr_i is pulsed
// in the cycle a sweep is (re)started so the first step is a full period.
module rss_step_timer #(
    parameter int unsigned RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              en_i,
    input  logic              dest_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              data_ce_i,
    output logic              tick_o
);
    logic [RATE_W-1:0] cnt_q;
    logic [RATE_W-1:0] period;
    logic              cnt_hit;

    // Derive the effective period, mapping 0 and 1 onto a single clock.
    always_comb begin
        period  = (rate_i <= RATE_W'(1)) ? RATE_W'(1) : rate_i;
        cnt_hit = (cnt_q == period - RATE_W'(1));
        tick_o  = en_i && (dest_i ? data_ce_i : cnt_hit);
    end

    // Count clocks between steps; restart on clear or on a counted hit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= cnt_hit ? '0 : cnt_q + RATE_W'(1);
        end
    end

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !dest_i) |-> (cnt_q < period)) else $error("timer overran period"); // R6
endmodule

// File: rtl/rss_walker.sv
// Address walker: loads the low bound on a start, then steps up and down
// between the bounds on each timer tick, flipping direction as each bound is
// presented. Assumes lo_i/hi_i are the captured bounds of the running sweep
// and load_lo_i/load_hi_i are the bounds of the sweep being started.
module rss_walker #(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic [ADDR_W-1:0] load_lo_i,
    input  logic [ADDR_W-1:0] load_hi_i,
    input  logic [ADDR_W-1:0] lo_i,
    input  logic [ADDR_W-1:0] hi_i,
    input  logic              tick_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              stb_o,
    output logic              up_o,
    output logic              run_o
);
    logic [ADDR_W-1:0] addr_q, step_addr;
    logic              stb_q, up_q, run_q, flat;

    // Next address in the current direction and the single-point case.
    always_comb begin
        step_addr = up_q ? addr_q + ADDR_W'(1) : addr_q - ADDR_W'(1);
        flat      = (lo_i == hi_i);
    end

    // Sweep state: start/abort has priority over stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            stb_q  <= 1'b0;
            up_q   <= 1'b1;
            run_q  <= 1'b0;
        end else if (trig_i) begin
            up_q <= 1'b1;
            if (load_lo_i <= load_hi_i) begin
                addr_q <= load_lo_i;
                stb_q  <= 1'b1;
                run_q  <= 1'b1;
            end else begin
                addr_q <= '0;
                stb_q  <= 1'b0;
                run_q  <= 1'b0;
            end
        end else if (run_q && tick_i) begin
            stb_q <= 1'b1;
            if (!flat) begin
                addr_q <= step_addr;
                up_q   <= up_q ? (step_addr != hi_i) : (step_addr == lo_i);
            end
        end else begin
            stb_q <= 1'b0;
        end
    end

    assign addr_o = addr_q;
    assign stb_o  = stb_q;
    assign up_o   = up_q;
    assign run_o  = run_q;

    AST_START_LOADS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && (load_lo_i <= load_hi_i)) |=> (run_q && stb_q && up_q && addr_q == $past(load_lo_i))) else $error("start"); // R2
    AST_ADDR_IN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (addr_q >= lo_i && addr_q <= hi_i)) else $error("bounds"); // R3
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && stb_q && $past(run_q) && !$past(trig_i) && !flat)
        |-> (addr_q == $past(addr_q) + ADDR_W'(1) || addr_q == $past(addr_q) - ADDR_W'(1))) else $error("step"); // R3
    AST_TURN_AT_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && stb_q && !flat && addr_q == hi_i) |-> !up_q) else $error("hi turn"); // R4
    AST_TURN_AT_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && stb_q && addr_q == lo_i) |-> up_q) else $error("lo turn"); // R4
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (!stb_q && addr_q == '0)) else $error("idle"); // R10
    AST_FLAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && flat && $past(run_q) && !$past(trig_i)) |-> $stable(addr_q)) else $error("flat"); // R9
endmodule

// File: rtl/ram_sweep_seq.sv
// Top: bidirectional waveform-RAM address sequencer with NSLOT configuration
// slots. Restarts on an update pulse or a synchronised select change and
// captures the chosen slot's parameters for the life of the sweep.
// Assumes slot fields are packed per slot index (see brief, R12).
module ram_sweep_seq
    import rss_pkg::*;
#(
    parameter int unsigned NSLOT = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          upd_i,
    input  logic [$clog2(NSLOT)-1:0]      sel_i,
    input  logic                          data_ce_i,
    input  logic [NSLOT*RSS_ADDR_W-1:0]   lo_i,
    input  logic [NSLOT*RSS_ADDR_W-1:0]   hi_i,
    input  logic [NSLOT*RSS_RATE_W-1:0]   rate_i,
    input  logic [NSLOT-1:0]              dest_i,
    output logic [RSS_ADDR_W-1:0]         rd_addr_o,
    output logic                          rd_stb_o,
    output logic                          dir_up_o,
    output logic [$clog2(NSLOT)-1:0]      slot_o,
    output logic                          dest_o
);
    localparam int unsigned SEL_W  = $clog2(NSLOT);
    localparam int unsigned ADDR_W = RSS_ADDR_W;
    localparam int unsigned RATE_W = RSS_RATE_W;

    slot_cfg_t        slots [NSLOT];
    slot_cfg_t        pick, act_q;
    logic [SEL_W-1:0] sel_s, slot_q;
    logic             sel_chg, trig, tick, run;

    // Unpack the flat slot buses into configuration records.
    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        assign slots[k].lo   = lo_i[k*ADDR_W +: ADDR_W];
        assign slots[k].hi   = hi_i[k*ADDR_W +: ADDR_W];
        assign slots[k].rate = rate_i[k*RATE_W +: RATE_W];
        assign slots[k].dest = dest_i[k];
    end

    rss_sel_sync #(.SEL_W(SEL_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_i (sel_i),
        .sel_o (sel_s),
        .chg_o (sel_chg)
    );

    // A start event is an update pulse or a settled select change.
    always_comb begin
        trig = upd_i || sel_chg;
        pick = slots[sel_s];
    end

    // Capture the chosen slot and its index at each start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= '0;
            slot_q <= '0;
        end else if (trig) begin
            act_q  <= pick;
            slot_q <= sel_s;
        end
    end

    rss_step_timer #(.RATE_W(RATE_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (trig),
        .en_i      (run),
        .dest_i    (act_q.dest),
        .rate_i    (act_q.rate),
        .data_ce_i (data_ce_i),
        .tick_o    (tick)
    );

    rss_walker #(.ADDR_W(ADDR_W)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_i    (trig),
        .load_lo_i (pick.lo),
        .load_hi_i (pick.hi),
        .lo_i      (act_q.lo),
        .hi_i      (act_q.hi),
        .tick_i    (tick),
        .addr_o    (rd_addr_o),
        .stb_o     (rd_stb_o),
        .up_o      (dir_up_o),
        .run_o     (run)
    );

    assign slot_o = slot_q;
    assign dest_o = act_q.dest;

    AST_SLOT_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        sel_chg |=> (slot_o == $past(sel_s))) else $error("slot"); // R5
endmodule

// File: tb/ram_sweep_seq_tb.sv
module ram_sweep_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int RW = 16;

    typedef struct {
        int addr;
        bit up;
        int slot;
        bit dest;
        int gap;
        string tag;
    } exp_t;

    logic clk = 0, rst_n = 0, upd = 0, sel = 0, ce = 0;
    logic [AW-1:0] b_lo [2];
    logic [AW-1:0] b_hi [2];
    logic [RW-1:0] b_rate [2];
    logic          b_dest [2];
    logic [2*AW-1:0] lo_bus, hi_bus;
    logic [2*RW-1:0] rate_bus;
    logic [1:0]      dest_bus;
    logic [AW-1:0]   rd_addr;
    logic            rd_stb, dir_up, slot, dest;

    exp_t q[$];
    bit   armed = 0;
    bit   ended = 0;
    int   checks = 0, errors = 0, cyc = 0, last_cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always_comb begin
        lo_bus   = {b_lo[1], b_lo[0]};
        hi_bus   = {b_hi[1], b_hi[0]};
        rate_bus = {b_rate[1], b_rate[0]};
        dest_bus = {b_dest[1], b_dest[0]};
    end

    ram_sweep_seq u_dut (
        .clk(clk), .rst_n(rst_n), .upd_i(upd), .sel_i(sel), .data_ce_i(ce),
        .lo_i(lo_bus), .hi_i(hi_bus), .rate_i(rate_bus), .dest_i(dest_bus),
        .rd_addr_o(rd_addr), .rd_stb_o(rd_stb), .dir_up_o(dir_up),
        .slot_o(slot), .dest_o(dest)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Data-clock enable toggles each cycle: one data-clock step every 2 clocks.
    initial forever begin
        @(posedge clk);
        #1 ce = ~ce;
    end

    // Monitor: pop and compare one expected item per observed strobe.
    always @(negedge clk) begin
        if (rst_n && armed && rd_stb) begin
            if (q.size() == 0) begin
                chk(0, "R11 unexpected strobe", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(int'(rd_addr) == e.addr, {e.tag, " address"}, int'(rd_addr), e.addr);
                chk(dir_up == e.up, {e.tag, " R4 direction"}, int'(dir_up), int'(e.up));
                chk(int'(slot) == e.slot, {e.tag, " R5 slot"}, int'(slot), e.slot);
                chk(dest == e.dest, {e.tag, " R7 dest"}, int'(dest), int'(e.dest));
                if (e.gap != 0)
                    chk(cyc - last_cyc == e.gap, {e.tag, " R11 spacing"}, cyc - last_cyc, e.gap);
            end
            last_cyc = cyc;
        end
    end

    // Driver: compute the expected bounce sequence, then trigger the start.
    task automatic play(int p, bit via_sel, int n, int gap, string tag);
        int a;
        bit up;
        @(posedge clk);
        #1;
        armed = 0;
        q.delete();
        a  = int'(b_lo[p]);
        up = 1;
        for (int k = 0; k < n; k++) begin
            exp_t e;
            e.addr = a; e.up = up; e.slot = p; e.dest = b_dest[p]; e.tag = tag;
            e.gap  = (k == 0 || (k == 1 && b_dest[p])) ? 0 : gap;
            q.push_back(e);
            if (b_lo[p] != b_hi[p]) begin
                if (up) begin
                    a++;
                    if (a == int'(b_hi[p])) up = 0;
                end else begin
                    a--;
                    if (a == int'(b_lo[p])) up = 1;
                end
            end
        end
        if (via_sel) begin
            sel = p[0];
            repeat (3) @(posedge clk);
            #1 armed = 1;
        end else begin
            upd = 1;
            @(posedge clk);
            #1 upd = 0;
            armed = 1;
        end
        for (int t = 0; t < 3000 && q.size() > 0; t++) @(posedge clk);
        #1;
        chk(q.size() == 0, {tag, " all expected addresses seen"}, q.size(), 0);
        armed = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk(0, "watchdog R1", 0, 1);
        finish_run();
    end

    initial begin
        b_lo[0] = 4;  b_hi[0] = 7;  b_rate[0] = 3; b_dest[0] = 0;
        b_lo[1] = 20; b_hi[1] = 22; b_rate[1] = 5; b_dest[1] = 1;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        // R1: idle after reset
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(rd_addr == 0, "R1 idle address", int'(rd_addr), 0);
            chk(rd_stb == 0, "R1 idle strobe", int'(rd_stb), 0);
            chk(slot == 0, "R1 idle slot", int'(slot), 0);
        end
        // R2 R3 R4 R6: counted mode, M=3, bounce 4..7 (R12 packing)
        play(0, 0, 10, 3, "R2 R3 R6 R12");
        // R5 R7: select change mid-sweep to data-clock slot 1
        play(1, 1, 8, 2, "R5 R7");
        // R8: M=0 and M=1 give one step per clock
        b_lo[0] = 0; b_hi[0] = 1; b_rate[0] = 0;
        play(0, 1, 6, 1, "R8 M0");
        b_lo[1] = 30; b_hi[1] = 33; b_rate[1] = 1; b_dest[1] = 0;
        play(1, 1, 9, 1, "R8 M1");
        // R9: equal bounds hold the address
        b_lo[0] = 9; b_hi[0] = 9; b_rate[0] = 2;
        play(0, 1, 5, 2, "R9");
        // R10: inverted bounds leave the block idle
        b_lo[0] = 12; b_hi[0] = 5;
        @(posedge clk);
        #1 upd = 1;
        @(posedge clk);
        #1 upd = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk(rd_stb == 0, "R10 no strobe", int'(rd_stb), 0);
            chk(rd_addr == 0, "R10 address zero", int'(rd_addr), 0);
        end
        // R10 R2: recovery on the next valid start
        b_lo[0] = 2; b_hi[0] = 3; b_rate[0] = 2;
        play(0, 0, 4, 2, "R10 R2 restart");
        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule